// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt requests for a small 8-bit core. The five requests are two external active-low pins, two timer overflow pulses, and one serial request. The serial request is the OR of a receive flag and a transmit flag. Software sets per-source enables, a master enable and a one-bit priority per source through a small write port.

The core marks the sampling point of each machine cycle with a strobe. Request flags are captured at one strobe. They are then arbitrated at the following strobe. When the core reports that it is in the final cycle of an ordinary instruction, the controller raises a one-clock acknowledge together with the vector address of the winner. It then marks the winner's level as in service.

Edge-latched external requests and timer overflows are cleared by hardware when they are vectored. Level requests and the serial request stay active until their source drops them. A return-from-interrupt reported by the core releases the highest level that is in service.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable and priority registers are zero, no level is in service, no acknowledge is issued, and pending requests do not vector while the master enable is off.
- R2: The vector addresses are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, and 0x0023 for serial.
- R3: The enable register is written with `cfg_sel`=0. Bit 7 is the master enable. Bits 0 to 4 enable external 0, timer 0, external 1, timer 1 and serial. A request is vectored only if both the master bit and its own bit are set.
- R4: The priority register is written with `cfg_sel`=1, with bits 0 to 4 in the same source order, and 1 means high. When requests of both levels are pending, the high one is vectored first.
- R5: Within one level the polling order is external 0, timer 0, external 1, timer 1, serial.
- R6: A request flag is captured on a clock edge with `cyc_stb`=1 and arbitrated on the next such edge. `irq_ack` is high for the one clock after that second edge, with `irq_vec` and `irq_lvl` valid.
- R7: No vector is issued on a strobe edge where `last_cyc`=0, `reti_cyc`=1 or `cfg_wr_cyc`=1.
- R8: A high request may preempt a low handler. A low request is vectored only when no level is in service. A high request is never vectored while a high handler is in service.
- R9: `in_svc` bit 0 is the low level and bit 1 the high level. The bit is set on vectoring. A strobe edge with `reti_cyc`=1 and `last_cyc`=1 clears the highest set bit.
- R10: `ext_edge_sel` bit i=1 selects falling-edge mode for external i. A high sample followed by a low sample of `ext_pin_n` at consecutive strobes latches a request, and vectoring clears it. With the bit at 0, the request is present while the pin is low and is never cleared by hardware.
- R11: A timer overflow pulse latches a request that vectoring clears. The serial request follows `ser_rx_flag` OR `ser_tx_flag` and is never cleared by hardware. `req_flags` shows the five live requests in the R3 bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_stb | input | 1 | Sampling strobe, once per machine cycle |
| last_cyc | input | 1 | Core is in the final cycle of its instruction |
| reti_cyc | input | 1 | Instruction is a return-from-interrupt |
| cfg_wr_cyc | input | 1 | Instruction writes the enable or priority register |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable, 1 selects priority |
| cfg_wdata | input | 8 | Register write data |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_sel | input | 2 | Per-pin trigger type, 1 means falling edge |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| irq_ack | output | 1 | One-clock vector acknowledge |
| irq_vec | output | 16 | Vector address of the last acknowledge |
| irq_lvl | output | 1 | Level of the last acknowledge, 1 means high |
| in_svc | output | 2 | In-service bits, bit 1 is the high level |
| req_flags | output | 5 | Live request flags |

## Verification
Vectoring and return-from-interrupt can meet on the same strobe, and so can a hardware clear and a fresh edge or overflow on the same source. The bench provokes these collisions by holding the return status high while requests wait. It also pulses overflows and toggles pins in random stimulus that runs alongside a cycle model. The judgement follows R7 and R9: the return must release a level and block the vector, and a new event arriving in the same cycle as the clear must leave the request latched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PAIRS   = 2;
  localparam int NSRC    = 2 * PAIRS + 1;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int LVLS    = 2;
  localparam int GIE_BIT = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  function automatic src_vec_t pick_first(input src_vec_t r);
    return r & (~r + 1'b1);
  endfunction

  function automatic logic [IDX_W-1:0] oh_to_idx(input src_vec_t oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (oh[k]) idx = idx | IDX_W'(k);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [PAIRS-1:0] pin_n,
  input  logic [PAIRS-1:0] edge_sel,
  input  logic [PAIRS-1:0] ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  src_vec_t         clr,
  output src_vec_t         flags
);
  logic [PAIRS-1:0] prev_q, prev_d;
  logic [PAIRS-1:0] lat_q, lat_d;
  logic [PAIRS-1:0] tf_q, tf_d;

  always_comb begin
    prev_d = prev_q;
    lat_d  = lat_q;
    tf_d   = tf_q;
    for (int i = 0; i < PAIRS; i++) begin
      if (stb) prev_d[i] = pin_n[i];
      if (stb && edge_sel[i] && prev_q[i] && !pin_n[i]) lat_d[i] = 1'b1;
      else if (clr[2*i])                                lat_d[i] = 1'b0;
      if (ovf[i])            tf_d[i] = 1'b1;
      else if (clr[2*i+1])   tf_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      lat_q  <= '0;
      tf_q   <= '0;
    end else begin
      prev_q <= prev_d;
      lat_q  <= lat_d;
      tf_q   <= tf_d;
    end
  end

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      assign flags[2*g]   = edge_sel[g] ? lat_q[g] : ~pin_n[g];
      assign flags[2*g+1] = tf_q[g];
    end
  endgenerate
  assign flags[NSRC-1] = ser_rx | ser_tx;
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic          gie,
  output src_vec_t      src_en,
  output src_vec_t      src_pri
);
  logic     gie_d;
  src_vec_t en_d, pri_d;

  always_comb begin
    gie_d = gie;
    en_d  = src_en;
    pri_d = src_pri;
    if (we) begin
      if (sel) begin
        pri_d = wdata[NSRC-1:0];
      end else begin
        en_d  = wdata[NSRC-1:0];
        gie_d = wdata[GIE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      src_en  <= '0;
      src_pri <= '0;
    end else begin
      gie     <= gie_d;
      src_en  <= en_d;
      src_pri <= pri_d;
    end
  end
endmodule

// File: rtl/irqc_poll.sv
module irqc_poll
  import irqc_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             last,
  input  logic             reti,
  input  logic             cfgwr,
  input  src_vec_t         flags,
  input  logic             gie,
  input  src_vec_t         src_en,
  input  src_vec_t         src_pri,
  input  logic [LVLS-1:0]  in_svc,
  output src_vec_t         grant_oh,
  output logic             grant_any,
  output logic             grant_lvl,
  output logic             ack,
  output logic [VEC_W-1:0] vec,
  output logic             lvl
);
  src_vec_t         snap_q, snap_d;
  src_vec_t         hi_req, lo_req;
  logic             open_win, pick_hi, pick_lo;
  logic [IDX_W-1:0] g_idx;
  logic [VEC_W-1:0] vec_d;
  logic             lvl_d;

  always_comb begin
    hi_req    = snap_q & src_pri;
    lo_req    = snap_q & ~src_pri;
    open_win  = stb && last && !reti && !cfgwr;
    pick_hi   = open_win && !in_svc[1] && (|hi_req);
    pick_lo   = open_win && (in_svc == '0) && !pick_hi && (|lo_req);
    grant_oh  = pick_hi ? pick_first(hi_req) : (pick_lo ? pick_first(lo_req) : '0);
    grant_any = pick_hi || pick_lo;
    grant_lvl = pick_hi;
    g_idx     = oh_to_idx(grant_oh);
    snap_d    = stb ? ((flags & src_en & {NSRC{gie}}) & ~grant_oh) : snap_q;
    vec_d     = grant_any ? VEC_W'(VEC_BASE + int'(g_idx) * VEC_STRIDE) : vec;
    lvl_d     = grant_any ? grant_lvl : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ack    <= 1'b0;
      vec    <= '0;
      lvl    <= 1'b0;
    end else begin
      snap_q <= snap_d;
      ack    <= grant_any;
      vec    <= vec_d;
      lvl    <= lvl_d;
    end
  end
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic            last,
  input  logic            reti,
  input  logic            grant_any,
  input  logic            grant_lvl,
  output logic [LVLS-1:0] in_svc
);
  logic [LVLS-1:0] svc_d;

  always_comb begin
    svc_d = in_svc;
    if (grant_any) begin
      svc_d[grant_lvl] = 1'b1;
    end else if (stb && reti && last) begin
      if (in_svc[1]) svc_d[1] = 1'b0;
      else           svc_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_svc <= '0;
    else        in_svc <= svc_d;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int CFG_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_stb,
  input  logic                 last_cyc,
  input  logic                 reti_cyc,
  input  logic                 cfg_wr_cyc,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [PAIRS-1:0]     ext_pin_n,
  input  logic [PAIRS-1:0]     ext_edge_sel,
  input  logic [PAIRS-1:0]     tmr_ovf,
  input  logic                 ser_rx_flag,
  input  logic                 ser_tx_flag,
  output logic                 irq_ack,
  output logic [VEC_W-1:0]     irq_vec,
  output logic                 irq_lvl,
  output logic [LVLS-1:0]      in_svc,
  output logic [NSRC-1:0]      req_flags
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       gie;
  src_vec_t   src_en, src_pri, grant_oh;
  logic       grant_any, grant_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  irqc_req_latch u_req (
    .clk(clk), .rst_n(rst_core_n), .stb(cyc_stb),
    .pin_n(ext_pin_n), .edge_sel(ext_edge_sel), .ovf(tmr_ovf),
    .ser_rx(ser_rx_flag), .ser_tx(ser_tx_flag),
    .clr(grant_oh), .flags(req_flags)
  );

  irqc_cfg_regs #(.DW(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .gie(gie), .src_en(src_en), .src_pri(src_pri)
  );

  irqc_poll #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_poll (
    .clk(clk), .rst_n(rst_core_n), .stb(cyc_stb), .last(last_cyc),
    .reti(reti_cyc), .cfgwr(cfg_wr_cyc), .flags(req_flags),
    .gie(gie), .src_en(src_en), .src_pri(src_pri), .in_svc(in_svc),
    .grant_oh(grant_oh), .grant_any(grant_any), .grant_lvl(grant_lvl),
    .ack(irq_ack), .vec(irq_vec), .lvl(irq_lvl)
  );

  irqc_svc u_svc (
    .clk(clk), .rst_n(rst_core_n), .stb(cyc_stb), .last(last_cyc),
    .reti(reti_cyc), .grant_any(grant_any), .grant_lvl(grant_lvl),
    .in_svc(in_svc)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_stb,
  input logic             last_cyc,
  input logic             reti_cyc,
  input logic             cfg_wr_cyc,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_lvl,
  input logic [LVLS-1:0]  in_svc
);
  p_ack_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(cyc_stb && last_cyc && !reti_cyc && !cfg_wr_cyc));

  p_svc_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> in_svc[irq_lvl]);

  p_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_lvl) |-> (in_svc == 2'b01));

  p_high_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_lvl) |-> !$past(in_svc[1]));

  p_vec_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ((int'(irq_vec) >= VEC_BASE) &&
                 (((int'(irq_vec) - VEC_BASE) % VEC_STRIDE) == 0) &&
                 (((int'(irq_vec) - VEC_BASE) / VEC_STRIDE) < NSRC)));

  p_svc_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_stb) |-> $stable(in_svc));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .last_cyc(last_cyc),
  .reti_cyc(reti_cyc), .cfg_wr_cyc(cfg_wr_cyc), .irq_ack(irq_ack),
  .irq_vec(irq_vec), .irq_lvl(irq_lvl), .in_svc(in_svc)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // DUT-side inputs, updated only inside tick
  logic       rst_n = 1'b0, cyc_stb = 1'b0, last_cyc = 1'b1, reti_cyc = 1'b0, cfg_wr_cyc = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_sel = 2'b00, tmr_ovf = 2'b00;
  logic       ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic        irq_ack, irq_lvl;
  logic [15:0] irq_vec;
  logic [1:0]  in_svc;
  logic [4:0]  req_flags;

  // stimulus requested by the test flow
  logic       b_rst_n = 1'b0, b_last = 1'b1, b_reti = 1'b0, b_cfgwr = 1'b0;
  logic       b_we = 1'b0, b_sel = 1'b0;
  logic [7:0] b_wd = 8'h00;
  logic [1:0] b_pin = 2'b11, b_edge = 2'b00, b_ovf = 2'b00;
  logic       b_rx = 1'b0, b_tx = 1'b0;

  // reference model state
  logic [1:0]  m_rs = 2'b00, m_prev = 2'b11, m_lat = 2'b00, m_tf = 2'b00, m_isr = 2'b00;
  logic        m_gie = 1'b0;
  logic [4:0]  m_en = 5'd0, m_pri = 5'd0, m_snap = 5'd0;
  logic        e_ack = 1'b0, e_lvl = 1'b0;
  logic [15:0] e_vec = 16'h0000;

  int   errors = 0, checks = 0;
  int   ph = 0;
  logic obs_ack = 1'b0;
  logic [15:0] obs_vec = 16'h0;
  logic last_stb = 1'b0;

  irq_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .last_cyc(last_cyc),
    .reti_cyc(reti_cyc), .cfg_wr_cyc(cfg_wr_cyc), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ext_pin_n(ext_pin_n),
    .ext_edge_sel(ext_edge_sel), .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag),
    .ser_tx_flag(ser_tx_flag), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .in_svc(in_svc), .req_flags(req_flags)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] m_flags();
    logic [4:0] f;
    f[0] = b_edge_applied(0) ? m_lat[0] : ~ext_pin_n[0];
    f[1] = m_tf[0];
    f[2] = b_edge_applied(1) ? m_lat[1] : ~ext_pin_n[1];
    f[3] = m_tf[1];
    f[4] = ser_rx_flag | ser_tx_flag;
    return f;
  endfunction

  function automatic logic b_edge_applied(input int i);
    return ext_edge_sel[i];
  endfunction

  // model of one clock edge, using the inputs now applied to the DUT
  task automatic model_edge();
    logic [4:0] fl, hi, lo, g;
    logic       open_w, ph_hi, ph_lo, rst_int;
    int         idx;
    if (!rst_n) begin
      m_rs = 2'b00; m_prev = 2'b11; m_lat = 2'b00; m_tf = 2'b00; m_isr = 2'b00;
      m_gie = 1'b0; m_en = 5'd0; m_pri = 5'd0; m_snap = 5'd0;
      e_ack = 1'b0; e_lvl = 1'b0; e_vec = 16'h0;
      return;
    end
    rst_int = m_rs[1];
    m_rs = {m_rs[0], 1'b1};
    if (!rst_int) begin
      e_ack = 1'b0;
      return;
    end
    fl     = m_flags();
    hi     = m_snap & m_pri;
    lo     = m_snap & ~m_pri;
    open_w = cyc_stb && last_cyc && !reti_cyc && !cfg_wr_cyc;
    ph_hi  = open_w && !m_isr[1] && (hi != 0);
    ph_lo  = open_w && (m_isr == 2'b00) && !ph_hi && (lo != 0);
    g = 5'd0; idx = 0;
    for (int k = 4; k >= 0; k--) begin
      if (ph_hi && hi[k]) begin g = 5'd1 << k; idx = k; end
      if (ph_lo && lo[k]) begin g = 5'd1 << k; idx = k; end
    end
    e_ack = (g != 0);
    if (e_ack) begin
      e_vec = 16'(3 + 8 * idx);
      e_lvl = ph_hi;
      m_isr[ph_hi] = 1'b1;
    end else if (cyc_stb && reti_cyc && last_cyc) begin
      if (m_isr[1]) m_isr[1] = 1'b0; else m_isr[0] = 1'b0;
    end
    if (cyc_stb) m_snap = fl & m_en & {5{m_gie}} & ~g;
    for (int i = 0; i < 2; i++) begin
      if (cyc_stb && ext_edge_sel[i] && m_prev[i] && !ext_pin_n[i]) m_lat[i] = 1'b1;
      else if (g[2*i]) m_lat[i] = 1'b0;
      if (cyc_stb) m_prev[i] = ext_pin_n[i];
      if (tmr_ovf[i]) m_tf[i] = 1'b1;
      else if (g[2*i+1]) m_tf[i] = 1'b0;
    end
    if (cfg_we) begin
      if (cfg_sel) m_pri = cfg_wdata[4:0];
      else begin m_en = cfg_wdata[4:0]; m_gie = cfg_wdata[7]; end
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    obs_ack = irq_ack;
    obs_vec = irq_vec;
    check(irq_ack === e_ack, tag, "ack", 16'(irq_ack), 16'(e_ack));
    check(in_svc === m_isr, tag, "in_svc", 16'(in_svc), 16'(m_isr));
    check(req_flags === m_flags(), tag, "req_flags", 16'(req_flags), 16'(m_flags()));
    if (e_ack) begin
      check(irq_vec === e_vec, tag, "vec", irq_vec, e_vec);
      check(irq_lvl === e_lvl, tag, "lvl", 16'(irq_lvl), 16'(e_lvl));
    end
    last_stb     = (ph == 3);
    ph           = (ph + 1) % 4;
    cyc_stb      = last_stb;
    rst_n        = b_rst_n;   last_cyc  = b_last;   reti_cyc   = b_reti;
    cfg_wr_cyc   = b_cfgwr;   cfg_we    = b_we;     cfg_sel    = b_sel;
    cfg_wdata    = b_wd;      ext_pin_n = b_pin;    ext_edge_sel = b_edge;
    tmr_ovf      = b_ovf;     ser_rx_flag = b_rx;   ser_tx_flag  = b_tx;
    model_edge();
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    b_we = 1'b1; b_sel = sel; b_wd = d;
    tick("R3");
    b_we = 1'b0;
  endtask

  task automatic ovf_pulse(input int i);
    b_ovf[i] = 1'b1;
    tick("R11");
    b_ovf = 2'b00;
  endtask

  task automatic wait_vec(input logic [15:0] exp, input string tag);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      tick(tag);
      if (obs_ack) seen = 1'b1;
    end
    check(seen && obs_vec === exp, tag, "directed vector", obs_vec, exp);
  endtask

  task automatic no_ack(input int n, input string tag);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(tag);
      if (obs_ack) seen = 1'b1;
    end
    check(!seen, tag, "unexpected ack", 16'(seen), 16'h0);
  endtask

  task automatic do_reti();
    b_reti = 1'b1;
    tick("R9");
    while (!last_stb) tick("R9");
    b_reti = 1'b0;
    tick("R9");
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1A2B3C4D));
    // R1: reset state
    ticks(4, "R1");
    b_rst_n = 1'b1;
    ticks(4, "R1");
    check(irq_ack === 1'b0 && in_svc === 2'b00, "R1", "reset outputs",
          {14'd0, in_svc} | 16'(irq_ack), 16'h0);
    check(req_flags === 5'b00000, "R1", "reset flags", 16'(req_flags), 16'h0);
    ovf_pulse(0);
    no_ack(16, "R1");
    // R2/R11: enabling releases the pending timer 0 request
    cfg_write(1'b0, 8'h9F);
    wait_vec(16'h000B, "R2");
    check(req_flags[1] === 1'b0, "R11", "timer flag cleared", 16'(req_flags[1]), 16'h0);
    do_reti();
    // R10: falling edge on external 0
    b_edge = 2'b01; tick("R10");
    b_pin[0] = 1'b0;
    wait_vec(16'h0003, "R10");
    check(req_flags[0] === 1'b0, "R10", "edge latch cleared", 16'(req_flags[0]), 16'h0);
    b_pin[0] = 1'b1;
    do_reti();
    no_ack(12, "R10");
    // R10: level external 1 re-requests after return
    b_pin[1] = 1'b0;
    wait_vec(16'h0013, "R10");
    do_reti();
    wait_vec(16'h0013, "R10");
    b_pin[1] = 1'b1;
    do_reti();
    // R11: timer 1 and serial
    ovf_pulse(1);
    wait_vec(16'h001B, "R11");
    do_reti();
    b_tx = 1'b1;
    wait_vec(16'h0023, "R11");
    do_reti();
    wait_vec(16'h0023, "R11");
    b_tx = 1'b0;
    do_reti();
    // R3: master enable off, then one source disabled
    cfg_write(1'b0, 8'h1F);
    ovf_pulse(1);
    no_ack(16, "R3");
    check(req_flags[3] === 1'b1, "R3", "masked request pending", 16'(req_flags[3]), 16'h1);
    cfg_write(1'b0, 8'h9F);
    wait_vec(16'h001B, "R3");
    do_reti();
    cfg_write(1'b0, 8'h9D);
    ovf_pulse(0);
    no_ack(16, "R3");
    cfg_write(1'b0, 8'h9F);
    wait_vec(16'h000B, "R3");
    do_reti();
    // R5: simultaneous low-level requests
    b_pin[1] = 1'b0; b_ovf[1] = 1'b1; b_rx = 1'b1;
    tick("R5");
    b_ovf = 2'b00;
    wait_vec(16'h0013, "R5");
    no_ack(12, "R8");
    b_pin[1] = 1'b1;
    do_reti();
    wait_vec(16'h001B, "R5");
    do_reti();
    wait_vec(16'h0023, "R5");
    b_rx = 1'b0;
    do_reti();
    // R4: high-priority serial against low external 0 level
    cfg_write(1'b1, 8'h10);
    b_edge = 2'b00; b_pin[0] = 1'b0; b_rx = 1'b1;
    wait_vec(16'h0023, "R4");
    no_ack(12, "R8");
    b_rx = 1'b0;
    do_reti();
    wait_vec(16'h0003, "R4");
    b_pin[0] = 1'b1;
    do_reti();
    // R8/R9: preemption by a high-level timer 0
    cfg_write(1'b1, 8'h02);
    b_pin[1] = 1'b0;
    wait_vec(16'h0013, "R8");
    ovf_pulse(0);
    wait_vec(16'h000B, "R8");
    check(in_svc === 2'b11, "R8", "nested levels", 16'(in_svc), 16'h3);
    ovf_pulse(0);
    no_ack(12, "R8");
    do_reti();
    check(in_svc === 2'b01, "R9", "high released first", 16'(in_svc), 16'h1);
    wait_vec(16'h000B, "R8");
    b_pin[1] = 1'b1;
    do_reti();
    do_reti();
    check(in_svc === 2'b00, "R9", "all released", 16'(in_svc), 16'h0);
    // R7: blocking windows
    cfg_write(1'b1, 8'h00);
    b_last = 1'b0;
    ovf_pulse(1);
    no_ack(16, "R7");
    b_last = 1'b1; b_cfgwr = 1'b1;
    no_ack(16, "R7");
    b_cfgwr = 1'b0; b_reti = 1'b1;
    no_ack(16, "R7");
    b_reti = 1'b0;
    wait_vec(16'h001B, "R7");
    do_reti();
    // R6: capture then arbitrate on the next strobe
    while (!last_stb) tick("R6");
    b_ovf[0] = 1'b1; tick("R6"); b_ovf = 2'b00;
    n = 0;
    for (int i = 0; i < 20 && !obs_ack; i++) begin tick("R6"); n++; end
    check(n == 8, "R6", "ack latency", 16'(n), 16'd8);
    do_reti();
    // random phase with mixed events, checked every clock by the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(7) == 0) b_pin[$urandom_range(1)] ^= 1'b1;
      if ($urandom_range(63) == 0) b_edge = 2'($urandom_range(3));
      b_ovf  = {($urandom_range(15) == 0), ($urandom_range(15) == 0)};
      if ($urandom_range(19) == 0) b_rx = ~b_rx;
      if ($urandom_range(29) == 0) b_tx = ~b_tx;
      b_last  = ($urandom_range(3) != 0);
      b_reti  = ($urandom_range(7) == 0);
      b_cfgwr = ($urandom_range(15) == 0);
      b_we    = ($urandom_range(39) == 0);
      b_sel   = 1'($urandom_range(1));
      b_wd    = 8'($urandom_range(255)) | (($urandom_range(7) != 0) ? 8'h80 : 8'h00);
      tick("R6 R8 R9 random");
    end
    b_we = 1'b0; b_ovf = 2'b00;
    ticks(8, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule